// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

A four-bit up-counter in which every state bit changes on the same rising clock edge. It can be preset from a parallel data input. Two count enables and a decoded carry output let several stages be joined into one wider synchronous counter. Each stage's carry drives the next stage's carry-gating enable, and the free-running enables of all stages are tied together.

Two compile-time parameters pick the variant. `DECADE` selects modulo-10 counting instead of modulo-16. `ASYNC_CLR` makes the clear input act at once instead of at the next clock edge. At a clock edge the actions rank as follows: clear first, then load, then count, then hold. A power-up reset input puts the count at zero. That reset is applied at once and removed in step with the clock.

Top module: `sync_cascade_counter`

## Requirements
- R1: While `rst_n` is low, `q` is 0. After `rst_n` rises, `q` stays 0 until a load or a count acts on it.
- R2: With `clr_n`, `ld_n`, `en_p` and `en_t` all high, `q` advances by one at each rising edge.
- R3: With `clr_n` and `ld_n` high and either enable low, `q` keeps its value across the edge. Input changes between edges never change `q`.
- R4: A low `ld_n` with `clr_n` high copies `din` into `q` at the next rising edge, whatever the levels of `en_p` and `en_t`.
- R5: With `ASYNC_CLR`=0, a low `clr_n` makes `q` 0 at the next rising edge. This overrides load and both enables.
- R6: With `ASYNC_CLR`=1, a low `clr_n` makes `q` 0 at once, without waiting for a clock edge.
- R7: With `DECADE`=0, counting goes from 15 to 0. With `DECADE`=1, counting goes from 9 to 0, so a count inside 0..9 stays inside 0..9.
- R8: With `DECADE`=1, a loaded value from 10 to 15 counts up by one each step and goes from 15 to 0. `rco` stays low in those states.
- R9: `rco` is combinational. It is high exactly when `en_t` is high and `q` equals the terminal count: 15 in binary mode, 9 in decade mode. `en_p` has no effect on it.
- R10: When a second binary stage has its `en_t` driven by the first stage's `rco` and shares its `en_p`, the two stages count as one 8-bit synchronous counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Power-up reset, active low, asserted at once and removed in step with the clock |
| clr_n | input | 1 | Clear, active low; synchronous or immediate depending on `ASYNC_CLR` |
| ld_n | input | 1 | Parallel load, active low |
| en_p | input | 1 | Count enable that does not affect the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| rco | output | 1 | Terminal-count carry |

## Verification
The assertions assume that `clr_n`, `ld_n`, `en_p`, `en_t` and `din` change only well away from a rising edge. In the immediate-clear variant, they also assume that `clr_n` is never released on an edge. The bench meets both assumptions by changing every input on the falling edge.

Random stimulus mixes clears, loads and the four enable combinations at fixed weights. Directed runs cover the binary and decade wrap points, the out-of-range decade states and an immediate clear made in the middle of a cycle. A second stage fed from the first stage's carry checks the cascade at its carry boundary.

// File: rtl/cnt_pkg.sv
package cnt_pkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;

  function automatic int unsigned term_of(input int unsigned width, input bit decade);
    return decade ? 32'd9 : ((32'd1 << width) - 32'd1);
  endfunction

endpackage

// File: rtl/cnt_rst_sync.sv
module cnt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/cnt_op_decode.sv
module cnt_op_decode
  import cnt_pkg::*;
#(
  parameter bit SYNC_CLR = 1'b1
) (
  input  logic    clr_n,
  input  logic    ld_n,
  input  logic    en_p,
  input  logic    en_t,
  output cnt_op_e op
);
  logic clr_req;

  generate
    if (SYNC_CLR) begin : g_sync
      assign clr_req = ~clr_n;
    end else begin : g_async
      assign clr_req = 1'b0;
    end
  endgenerate

  always_comb begin
    if (clr_req)            op = OP_CLEAR;
    else if (!ld_n)         op = OP_LOAD;
    else if (en_p && en_t)  op = OP_COUNT;
    else                    op = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next_state.sv
module cnt_next_state
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  cnt_op_e          op,
  input  logic [WIDTH-1:0] q_cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q_nxt
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_of(WIDTH, DECADE));

  logic [WIDTH-1:0] q_inc;

  always_comb begin
    q_inc = (q_cur == TERM) ? '0 : q_cur + 1'b1;
    unique case (op)
      OP_CLEAR: q_nxt = '0;
      OP_LOAD:  q_nxt = din;
      OP_COUNT: q_nxt = q_inc;
      default:  q_nxt = q_cur;
    endcase
  end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry
  import cnt_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic [WIDTH-1:0] q_cur,
  input  logic             en_t,
  output logic             rco
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_of(WIDTH, DECADE));

  assign rco = en_t & (q_cur == TERM);
endmodule

// File: rtl/sync_cascade_counter.sv
module sync_cascade_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH      = 4,
  parameter bit DECADE     = 1'b0,
  parameter bit ASYNC_CLR  = 1'b0,
  parameter int RST_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_n,
  input  logic             ld_n,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] q,
  output logic             rco
);
  localparam logic [WIDTH-1:0] TERM = WIDTH'(term_of(WIDTH, DECADE));

  logic             rst_core_n;
  logic             arst_n;
  cnt_op_e          op;
  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;
  logic             q_en;

  cnt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  generate
    if (ASYNC_CLR) begin : g_aclr
      assign arst_n = rst_core_n & clr_n;
    end else begin : g_sclr
      assign arst_n = rst_core_n;
    end
  endgenerate

  cnt_op_decode #(.SYNC_CLR(!ASYNC_CLR)) u_dec (
    .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t), .op(op)
  );

  cnt_next_state #(.WIDTH(WIDTH), .DECADE(DECADE)) u_nxt (
    .op(op), .q_cur(q_r), .din(din), .q_nxt(q_nxt)
  );

  assign q_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)   q_r <= '0;
    else if (q_en) q_r <= q_nxt;
  end

  cnt_carry #(.WIDTH(WIDTH), .DECADE(DECADE)) u_rco (
    .q_cur(q_r), .en_t(en_t), .rco(rco)
  );

  assign q = q_r;

  AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |-> q == '0); // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!arst_n)
    (clr_n && ld_n && en_p && en_t) |=> (q == WIDTH'($past(q) + 1'b1)) || (q == '0)); // R2
  AST_HOLD_STATE: assert property (@(posedge clk) disable iff (!arst_n)
    (clr_n && ld_n && !(en_p && en_t)) |=> $stable(q)); // R3
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!arst_n)
    (clr_n && !ld_n) |=> q == $past(din)); // R4
  AST_RCO_GATED: assert property (@(posedge clk) disable iff (!arst_n)
    rco |-> en_t); // R9
  AST_RCO_AT_TERM: assert property (@(posedge clk) disable iff (!arst_n)
    rco |-> q == TERM); // R9

  generate
    if (ASYNC_CLR) begin : g_chk_aclr
      AST_ASYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_core_n)
        !clr_n |-> q == '0); // R6
    end else begin : g_chk_sclr
      AST_SYNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_core_n)
        !clr_n |=> q == '0); // R5
    end
    if (DECADE) begin : g_chk_dec
      AST_DEC_RANGE: assert property (@(posedge clk) disable iff (!arst_n)
        (clr_n && ld_n && q <= TERM) |=> q <= TERM); // R7
    end
  endgenerate
endmodule

// File: tb/sim_sync_cascade_counter.sv
`timescale 1ns/1ps
module sim_sync_cascade_counter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n = 1'b1, ld_n = 1'b1, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] q0, q1, q2;
  logic rco0, rco1, rco2;
  logic [3:0] m0, m1, m2;
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  // u0: binary, synchronous clear
  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q0), .rco(rco0));
  // u1: decade, immediate clear
  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b1), .ASYNC_CLR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(en_t),
    .din(din), .q(q1), .rco(rco1));
  // u2: upper binary stage of a cascade with u0
  sync_cascade_counter #(.WIDTH(4), .DECADE(1'b0), .ASYNC_CLR(1'b0)) u2 (
    .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .en_p(en_p), .en_t(rco0),
    .din(din), .q(q2), .rco(rco2));

  function automatic logic [3:0] nxt(input logic [3:0] s, input bit dec, input logic clr,
                                     input logic ld, input logic go, input logic [3:0] d);
    if (!clr) return 4'd0;
    if (!ld) return d;
    if (go) begin
      if (dec && s == 4'd9) return 4'd0;
      return s + 4'd1;
    end
    return s;
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge: drive, check carries, take edge, check counts
  task automatic cycle(input logic c, input logic l, input logic p, input logic t,
                       input logic [3:0] d, input string tag);
    logic go2;
    clr_n = c; ld_n = l; en_p = p; en_t = t; din = d;
    if (!c) m1 = 4'd0;  // R6 immediate clear in the decade stage
    #1;
    chk("R9 rco binary", {3'd0, rco0}, {3'd0, t && m0 == 4'd15});
    chk("R9 rco decade", {3'd0, rco1}, {3'd0, t && m1 == 4'd9});
    chk("R10 rco cascade", {3'd0, rco2}, {3'd0, t && m0 == 4'd15 && m2 == 4'd15});
    @(posedge clk);
    go2 = p && t && (m0 == 4'd15);
    m2 = nxt(m2, 1'b0, c, l, go2, d);
    m0 = nxt(m0, 1'b0, c, l, p && t, d);
    m1 = nxt(m1, 1'b1, c, l, p && t, d);
    @(negedge clk);
    chk({tag, " binary"}, q0, m0);
    chk({tag, " decade"}, q1, m1);
    chk("R10 cascade upper", q2, m2);
  endtask

  function automatic string tag_of(input logic c, input logic l, input logic p, input logic t);
    if (!c) return "R5";
    if (!l) return "R4";
    if (p && t) return "R2";
    return "R3";
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m0 = 4'd0; m1 = 4'd0; m2 = 4'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset binary", q0, 4'd0);
    chk("R1 reset decade", q1, 4'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after release binary", q0, 4'd0);
    chk("R1 after release decade", q1, 4'd0);
    chk("R1 after release cascade", q2, 4'd0);

    // R3: toggle inputs between edges with counting disabled
    cycle(1, 1, 1, 0, 4'd5, "R3");
    cycle(1, 1, 0, 1, 4'd7, "R3");
    // R7: binary wrap 14,15,0 and decade wrap 8,9,0
    cycle(1, 0, 0, 0, 4'd14, "R4");
    cycle(1, 1, 1, 1, 4'd0, "R7");
    cycle(1, 1, 1, 1, 4'd0, "R7");
    cycle(1, 0, 1, 1, 4'd8, "R4");
    cycle(1, 1, 1, 1, 4'd0, "R7");
    cycle(1, 1, 1, 1, 4'd0, "R7");
    // R8: decade stage out of range 12..15 then 0
    cycle(1, 0, 1, 1, 4'd12, "R4");
    for (int i = 0; i < 5; i++) cycle(1, 1, 1, 1, 4'd0, "R8");
    // R5 over load
    cycle(0, 0, 1, 1, 4'd9, "R5");
    // R6: immediate clear in the middle of a cycle
    cycle(1, 0, 0, 0, 4'd6, "R4");
    clr_n = 1'b0;
    #1;
    chk("R6 immediate clear decade", q1, 4'd0);
    chk("R5 sync stage waits for edge", q0, m0);
    m1 = 4'd0;
    cycle(0, 1, 1, 1, 4'd0, "R5");
    // R10: carry into upper stage
    cycle(1, 0, 0, 0, 4'd13, "R4");
    for (int i = 0; i < 40; i++) cycle(1, 1, 1, 1, 4'd0, "R10");

    for (int i = 0; i < 600; i++) begin
      logic c, l, p, t;
      logic [3:0] d;
      c = ($urandom % 16) != 0;
      l = ($urandom % 8) != 0;
      p = ($urandom % 4) != 0;
      t = ($urandom % 4) != 0;
      d = 4'($urandom);
      cycle(c, l, p, t, d, tag_of(c, l, p, t));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule